// File: doc/BRIEF.md
# Double SHA-256 Nonce Search Engine

This block hunts for a qualifying 32-bit nonce in an 80-byte block header. The first 64 bytes of the header have already been compressed elsewhere, so the caller passes in the resulting 256-bit chaining value. The caller also passes the three fixed words that come before the nonce in the second 64-byte chunk: the low word of the transaction root, the timestamp, and the compact difficulty. A start strobe latches the work and sweeps the nonce upward from zero. For each nonce the block builds the padded second chunk and compresses it, starting from the latched chaining value. It then pads the 256-bit digest into a second block and compresses that block from the standard SHA-256 initial values.

Rounds are folded onto a pipeline of round units. `LOOP_LOG2` sets how many consecutive rounds each unit runs: 2^LOOP_LOG2, from 1 up to 32. The unit count is therefore 128 >> LOOP_LOG2, and a new trial enters every 2^LOOP_LOG2 cycles. Each trial carries its nonce and a valid tag down the pipeline. A qualifying result is reported with the exact nonce that produced it, so pipeline latency needs no further correction. `ZERO_BITS` narrows the hit test for testing. `NONCE_LAST` caps the sweep.

Top module: `dsha_nonce_search`

## Requirements
- R1: The first compression starts from `midstate` and does not use the standard IV. Word i of `midstate` sits in bits [32i+31:32i], with word 0 being A. Its message block words 0..15 are: `root_tail`, `time_stamp`, `diff_bits`, the nonce, 0x80000000, nine zero words, 0x00000000 and 0x00000280. The first digest is the compression result added word by word to `midstate`.
- R2: The second compression starts from the standard SHA-256 initial values. Its message block is digest words 0..7, then 0x80000000, six zero words and 0x00000100. The final H word is state word 7 after adding the IV.
- R3: A trial is a hit exactly when the low `ZERO_BITS` bits of the final H word are zero. With the default of 32, this means the whole word is zero. Every hit is reported and nothing else is.
- R4: A hit raises `found_valid` for one cycle, for a step size above one. In that same cycle, `found_nonce` holds the nonce that produced the hit. `found_nonce` holds its value between hits.
- R5: Nonces are issued in ascending order from 0, one every P = 2^LOOP_LOG2 cycles. Let the start strobe be sampled at a clock edge. The result for nonce n is visible in the cycle that follows the edge 1 + (S + n)·P edges later, where S = 128/P.
- R6: A start strobe has two effects. It latches the four work inputs and restarts the sweep at nonce 0. It also discards every trial still in flight, so no result from earlier work is reported after it. In the cycle after the strobe, `found_valid` and `done` are low.
- R7: `done` goes high in the cycle where the result for nonce `NONCE_LAST` is due. It stays high with no further hits until the next start strobe.
- R8: After reset, `found_valid`, `done` and `found_nonce` are zero, and no search runs until the first start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch work inputs and restart sweep at nonce 0 |
| midstate | input | 256 | Chaining value after the first header chunk, word 0 (A) in bits 31:0 |
| root_tail | input | 32 | Message word 0 of the second chunk |
| time_stamp | input | 32 | Message word 1 of the second chunk |
| diff_bits | input | 32 | Message word 2 of the second chunk |
| found_valid | output | 1 | One-cycle hit pulse |
| found_nonce | output | 32 | Nonce that produced the latest hit |
| done | output | 1 | Sweep exhausted and all trials resolved |

## Verification
Each hit is due a fixed number of cycles after the start edge: 1 + (S + n)·P, where n is the winning nonce. The bench records the cycle counter at every `found_valid` pulse and compares it with that formula, using its own model's list of winning nonces. `done` must rise exactly at the slot of the final nonce, and the bench checks it at that cycle. Outputs are sampled on falling edges. Every expected cycle is therefore counted in rising edges from the edge that sampled the strobe. A restart issued mid-sweep must produce no pulse from the earlier work, and the bench checks this by keeping the timing and contents of the post-restart pulses strictly aligned with the new job's model.

// File: rtl/dsha_pkg.sv
package dsha_pkg;
   typedef logic [31:0]       word_t;
   typedef logic [7:0][31:0]  state_t;
   typedef logic [15:0][31:0] block_t;

   localparam word_t RK [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
   };

   localparam state_t SHA_IV = {
      32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
      32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
   };

   function automatic word_t rotr(word_t x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic word_t lsig0(word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t lsig1(word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

   // one compression round; s[0] is A, s[7] is H
   function automatic state_t sha_step(state_t s, word_t k, word_t w);
      word_t  t1, t2;
      state_t r;
      t1 = s[7] + (rotr(s[4], 6) ^ rotr(s[4], 11) ^ rotr(s[4], 25))
           + ((s[4] & s[5]) ^ (~s[4] & s[6])) + k + w;
      t2 = (rotr(s[0], 2) ^ rotr(s[0], 13) ^ rotr(s[0], 22))
           + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
      r[0] = t1 + t2;
      r[1] = s[0];
      r[2] = s[1];
      r[3] = s[2];
      r[4] = s[3] + t1;
      r[5] = s[4];
      r[6] = s[5];
      r[7] = s[6];
      return r;
   endfunction

   // slide the 16-word schedule window by one word
   function automatic block_t sched_slide(block_t w);
      block_t r;
      for (int i = 0; i < 15; i++) r[i] = w[i+1];
      r[15] = lsig1(w[14]) + w[9] + lsig0(w[1]) + w[0];
      return r;
   endfunction

   function automatic block_t header_block(word_t w0, word_t w1, word_t w2, word_t nonce);
      block_t r;
      r     = '0;
      r[0]  = w0;
      r[1]  = w1;
      r[2]  = w2;
      r[3]  = nonce;
      r[4]  = 32'h8000_0000;
      r[15] = 32'h0000_0280;
      return r;
   endfunction

   function automatic block_t digest_block(state_t d);
      block_t r;
      r = '0;
      for (int i = 0; i < 8; i++) r[i] = d[i];
      r[8]  = 32'h8000_0000;
      r[15] = 32'h0000_0100;
      return r;
   endfunction

   function automatic state_t state_add(state_t a, state_t b);
      state_t r;
      for (int i = 0; i < 8; i++) r[i] = a[i] + b[i];
      return r;
   endfunction
endpackage

// File: rtl/dsha_work_feed.sv
module dsha_work_feed
   import dsha_pkg::*;
#(
   parameter int    PW         = 5,
   parameter int    PH_MAX     = 31,
   parameter word_t NONCE_LAST = 32'hFFFF_FFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [255:0]  mid_in,
   input  word_t         tail_in,
   input  word_t         time_in,
   input  word_t         bits_in,
   output logic          load,
   output logic [PW-1:0] phase,
   output state_t        mid_q,
   output block_t        blk,
   output word_t         nonce,
   output logic          active,
   output logic          exhausted
);
   word_t tail_q, time_q, bits_q;

   assign load = (phase == '0);
   assign blk  = header_block(tail_q, time_q, bits_q, nonce);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= '0;
         mid_q     <= '0;
         tail_q    <= '0;
         time_q    <= '0;
         bits_q    <= '0;
         nonce     <= '0;
         active    <= 1'b0;
         exhausted <= 1'b0;
      end else if (start) begin
         phase     <= '0;
         mid_q     <= state_t'(mid_in);
         tail_q    <= tail_in;
         time_q    <= time_in;
         bits_q    <= bits_in;
         nonce     <= '0;
         active    <= 1'b1;
         exhausted <= 1'b0;
      end else begin
         phase <= (phase == PW'(PH_MAX)) ? '0 : phase + 1'b1;
         if (load && active) begin
            if (nonce == NONCE_LAST) begin
               active    <= 1'b0;
               exhausted <= 1'b1;
            end else begin
               nonce <= nonce + 32'd1;
            end
         end
      end
   end

   p_nonce_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && active && !start && nonce != NONCE_LAST) |=> (nonce == $past(nonce) + 32'd1));
   p_exhaust_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> !active);
endmodule

// File: rtl/dsha_round_unit.sv
module dsha_round_unit
   import dsha_pkg::*;
#(
   parameter int BASE = 0,
   parameter int PW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          load,
   input  logic [PW-1:0] phase,
   input  state_t        in_st,
   input  block_t        in_w,
   input  word_t         in_nonce,
   input  logic          in_valid,
   output state_t        st_q,
   output block_t        w_q,
   output word_t         nonce_q,
   output logic          valid_q
);
   logic [5:0] kidx;
   assign kidx = 6'(BASE + int'(phase));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         w_q     <= '0;
         nonce_q <= '0;
         valid_q <= 1'b0;
      end else if (flush) begin
         valid_q <= 1'b0;
      end else if (load) begin
         st_q    <= sha_step(in_st, RK[kidx], in_w[0]);
         w_q     <= sched_slide(in_w);
         nonce_q <= in_nonce;
         valid_q <= in_valid;
      end else begin
         st_q <= sha_step(st_q, RK[kidx], w_q[0]);
         w_q  <= sched_slide(w_q);
      end
   end

   p_tag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !flush) |=> ($stable(nonce_q) && $stable(valid_q)));
   p_flush_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !valid_q);
endmodule

// File: rtl/dsha_nonce_search.sv
module dsha_nonce_search
   import dsha_pkg::*;
#(
   parameter int          LOOP_LOG2  = 5,
   parameter int          ZERO_BITS  = 32,
   parameter logic [31:0] NONCE_LAST = 32'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [255:0] midstate,
   input  logic [31:0]  root_tail,
   input  logic [31:0]  time_stamp,
   input  logic [31:0]  diff_bits,
   output logic         found_valid,
   output logic [31:0]  found_nonce,
   output logic         done
);
   localparam int STEP   = 1 << LOOP_LOG2;
   localparam int PH_MAX = STEP - 1;
   localparam int PW     = (LOOP_LOG2 == 0) ? 1 : LOOP_LOG2;
   localparam int NH     = 64 / STEP;
   localparam int NS     = 2 * NH;

   if (LOOP_LOG2 < 0 || LOOP_LOG2 > 5) begin : g_bad_loop
      $error("LOOP_LOG2 must lie in 0..5");
   end
   if (ZERO_BITS < 1 || ZERO_BITS > 32) begin : g_bad_zero
      $error("ZERO_BITS must lie in 1..32");
   end

   logic          load, active, exhausted;
   logic [PW-1:0] phase;
   state_t        mid_q;
   block_t        blk0;
   word_t         nonce0;

   dsha_work_feed #(.PW(PW), .PH_MAX(PH_MAX), .NONCE_LAST(NONCE_LAST)) u_feed (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mid_in(midstate), .tail_in(root_tail), .time_in(time_stamp), .bits_in(diff_bits),
      .load(load), .phase(phase), .mid_q(mid_q), .blk(blk0), .nonce(nonce0),
      .active(active), .exhausted(exhausted)
   );

   state_t          st_q    [NS];
   block_t          w_q     [NS];
   word_t           nonce_q [NS];
   logic [NS-1:0]   v_vec;

   for (genvar j = 0; j < NS; j++) begin : g_unit
      state_t s_in;
      block_t b_in;
      word_t  n_in;
      logic   v_in;
      if (j == 0) begin : g_head
         assign s_in = mid_q;
         assign b_in = blk0;
         assign n_in = nonce0;
         assign v_in = active;
      end else if (j == NH) begin : g_second
         assign s_in = SHA_IV;
         assign b_in = digest_block(state_add(st_q[j-1], mid_q));
         assign n_in = nonce_q[j-1];
         assign v_in = v_vec[j-1];
      end else begin : g_chain
         assign s_in = st_q[j-1];
         assign b_in = w_q[j-1];
         assign n_in = nonce_q[j-1];
         assign v_in = v_vec[j-1];
      end
      dsha_round_unit #(.BASE((j % NH) * STEP), .PW(PW)) u_unit (
         .clk(clk), .rst_n(rst_n), .flush(start), .load(load), .phase(phase),
         .in_st(s_in), .in_w(b_in), .in_nonce(n_in), .in_valid(v_in),
         .st_q(st_q[j]), .w_q(w_q[j]), .nonce_q(nonce_q[j]), .valid_q(v_vec[j])
      );
   end

   word_t fin_h;
   logic  hit;
   assign fin_h = st_q[NS-1][7] + SHA_IV[7];
   assign hit   = v_vec[NS-1] && (fin_h[ZERO_BITS-1:0] == '0);
   assign done  = exhausted && (v_vec == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_valid <= 1'b0;
         found_nonce <= '0;
      end else if (start) begin
         found_valid <= 1'b0;
      end else if (load) begin
         found_valid <= hit;
         if (hit) found_nonce <= nonce_q[NS-1];
      end else begin
         found_valid <= 1'b0;
      end
   end

   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (STEP > 1 && found_valid) |=> !found_valid);
   p_nonce_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!found_valid && !$rose(found_valid)) |-> $stable(found_nonce));
   p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!found_valid && !done));
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (!found_valid && done));
endmodule

// File: tb/dsha_nonce_search_test.sv
module dsha_nonce_search_test;
   localparam int          LL   = 2;
   localparam int          ZB   = 3;
   localparam logic [31:0] NL   = 32'd63;
   localparam int          P    = 1 << LL;
   localparam int          S    = 128 / P;

   localparam logic [31:0] KT [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
   };
   localparam logic [255:0] IVT = {
      32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
      32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
   };

   // job vectors: {midstate, root_tail, time_stamp, diff_bits}
   localparam logic [351:0] JOBS [3] = '{
      {256'h1f3a9c04_77e2b615_c0d48a29_5b6e0f93_a2c7143e_e98b5d70_3406f1ab_8d2e67c1,
       32'h4e1a22b7, 32'h4dab35f0, 32'h1a0b3c2e},
      {256'h90ab3c5d_e1f20718_6b4c9d2e_03a5f7b1_c8d90e2f_4a6b8c1d_5e7f9012_a3b4c5d6,
       32'h00000000, 32'h5f5e1000, 32'h1d00ffff},
      {256'hffffffff_00000000_12345678_9abcdef0_0f0f0f0f_f0f0f0f0_deadbeef_cafef00d,
       32'hffffffff, 32'h60a1b2c3, 32'h17034219}
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [255:0] midstate;
   logic [31:0]  root_tail, time_stamp, diff_bits;
   logic         found_valid;
   logic [31:0]  found_nonce;
   logic         done;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dsha_nonce_search #(.LOOP_LOG2(LL), .ZERO_BITS(ZB), .NONCE_LAST(NL)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .midstate(midstate),
      .root_tail(root_tail), .time_stamp(time_stamp), .diff_bits(diff_bits),
      .found_valid(found_valid), .found_nonce(found_nonce), .done(done)
   );

   function automatic logic [31:0] rr(logic [31:0] x, int n);
      logic [63:0] y;
      y = {x, x} >> n;
      return y[31:0];
   endfunction

   function automatic logic [255:0] ref_compress(logic [255:0] st, logic [511:0] blk);
      logic [31:0] w [64];
      logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
      for (int t = 0; t < 16; t++) w[t] = blk[32*t +: 32];
      for (int t = 16; t < 64; t++)
         w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
              + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
      a = st[31:0];    b = st[63:32];   c = st[95:64];   d = st[127:96];
      e = st[159:128]; f = st[191:160]; g = st[223:192]; h = st[255:224];
      for (int t = 0; t < 64; t++) begin
         t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
         t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
         h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
      end
      return {h + st[255:224], g + st[223:192], f + st[191:160], e + st[159:128],
              d + st[127:96],  c + st[95:64],   b + st[63:32],   a + st[31:0]};
   endfunction

   // R1 R2 R3: reference verdict for one nonce
   function automatic logic ref_hit(logic [351:0] job, logic [31:0] n);
      logic [511:0] b1, b2;
      logic [255:0] d1, d2;
      b1 = '0;
      b1[31:0]    = job[95:64];
      b1[63:32]   = job[63:32];
      b1[95:64]   = job[31:0];
      b1[127:96]  = n;
      b1[159:128] = 32'h8000_0000;
      b1[511:480] = 32'h0000_0280;
      d1 = ref_compress(job[351:96], b1);
      b2 = '0;
      b2[255:0]   = d1;
      b2[287:256] = 32'h8000_0000;
      b2[511:480] = 32'h0000_0100;
      d2 = ref_compress(IVT, b2);
      return d2[224 +: ZB] == '0;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [351:0] job, output int c0);
      @(negedge clk);
      midstate   = job[351:96];
      root_tail  = job[95:64];
      time_stamp = job[63:32];
      diff_bits  = job[31:0];
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c0    = cyc;
      chk(!found_valid && !done, "R6 outputs low after start", {found_valid, done}, 0);
   endtask

   task automatic run_job(input logic [351:0] job);
      logic [31:0] ex [64];
      int en = 0;
      int got = 0;
      int c0;
      int dc = -1;
      for (int n = 0; n <= int'(NL); n++)
         if (ref_hit(job, 32'(n))) begin ex[en] = 32'(n); en++; end
      pulse_start(job, c0);
      for (int k = 0; k < 1000 && dc < 0; k++) begin
         @(negedge clk);
         if (found_valid) begin
            if (got < en) begin
               chk(found_nonce == ex[got], "R1 R2 R4 winning nonce", found_nonce, ex[got]);
               chk(cyc == c0 + 1 + (S + int'(ex[got])) * P, "R5 hit cycle",
                   cyc - c0, 1 + (S + int'(ex[got])) * P);
            end else begin
               chk(1'b0, "R3 unexpected hit", found_nonce, 0);
            end
            got++;
         end
         if (done) dc = cyc;
      end
      chk(got == en, "R3 hit count", got, en);
      chk(dc == c0 + 1 + (S + int'(NL)) * P, "R7 done cycle", dc - c0, 1 + (S + int'(NL)) * P);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (found_valid || !done) chk(1'b0, "R7 quiet after done", {found_valid, done}, 1);
      end
      chk(done, "R7 done held", done, 1);
   endtask

   initial begin
      int c_dummy;
      int idle_hits = 0;
      rst_n = 1'b0; start = 1'b0;
      midstate = '0; root_tail = '0; time_stamp = '0; diff_bits = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(found_valid == 1'b0, "R8 found_valid at reset", found_valid, 0);
      chk(done == 1'b0, "R8 done at reset", done, 0);
      chk(found_nonce == 32'd0, "R8 found_nonce at reset", found_nonce, 0);
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (found_valid || done) idle_hits++;
      end
      chk(idle_hits == 0, "R8 idle before start", idle_hits, 0);

      for (int i = 0; i < 3; i++) run_job(JOBS[i]);

      // R6: abandon job 0 partway, then job 1 must report only its own hits
      pulse_start(JOBS[0], c_dummy);
      repeat (150) @(negedge clk);
      run_job(JOBS[1]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule